// File: doc/BRIEF.md
# Partitioned residue extractor for moduli one away from a power of two

This block reduces an unsigned operand to its residue modulo m, where m is either 2^k−1 or 2^k+1. The operand is cut into equal slices of s bits, with s a whole multiple of k. The last slice is zero-extended when the operand width is not a multiple of s. Each slice is reduced on its own by folding its k-bit digits. The slice residues then meet in a binary tree of modular adders.

For m = 2^k−1 every slice carries weight one. The adders add, feed the carry back into the low bits, and turn an all-ones sum into zero. For m = 2^k+1 the weight of slice i is (−1)^(i·s/k). When s/k is odd, the first tree level subtracts each odd slice from its even neighbour, and every level above it adds. The result is registered once, so the residue of the operand applied before a rising edge appears after that edge.

The width of the residue port is k bits for 2^k−1 and k+1 bits for 2^k+1. It always carries the canonical value in 0..m−1.

Top module: `rext_top`

## Requirements
- R1: While rst_ni is low, res_o is 0, whatever op_i holds.
- R2: After each rising clock edge out of reset, res_o equals the residue of the op_i sampled at that edge. It does not change while op_i stays constant.
- R3: res_o is always below m. The codes m and all-ones (for 2^k−1) never appear on the port.
- R4: For m = 2^k−1, res_o equals op_i mod m. Every multiple of m, including operands whose digit sums fold to all ones, gives 0.
- R5: For m = 2^k+1 with s/k even, every slice is added, and res_o equals op_i mod m.
- R6: For m = 2^k+1 with s/k odd, odd-indexed slices are subtracted, and res_o equals op_i mod m.
- R7: When the operand width is not a multiple of s, the top slice is zero-extended, and res_o equals op_i mod m.
- R8: With a single slice (s at least the operand width), the tree is empty and res_o equals op_i mod m.
- R9: Operand 0 gives 0, and the operand of all ones gives its true residue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | DATA_W | Unsigned operand |
| res_o | output | K+1 for 2^k+1, K otherwise | Registered residue op_i mod m |

## Verification
The hardest cases to reach are two. One is the 2^k+1 subtracting path, where an odd slice's residue exceeds its even neighbour's and the raw difference goes negative. The other is the 2^k−1 end-around path, where the folded sum lands exactly on all ones. Both depend on particular digit patterns inside individual slices, not on the operand as a whole. The stimulus therefore sweeps all 65536 16-bit operands through six parameter sets at once. Two of those sets have an odd digit count per slice. It then drives long runs of exact multiples of each modulus, which must all fold to zero.

// File: rtl/rext_pkg.sv
`timescale 1ns/1ps
package rext_pkg;
  typedef enum logic {MOD_MINUS = 1'b0, MOD_PLUS = 1'b1} mod_kind_e;

  function automatic int ceil_div(int a, int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int mod_val(int k, mod_kind_e kind);
    return (kind == MOD_PLUS) ? (1 << k) + 1 : (1 << k) - 1;
  endfunction
endpackage

// File: rtl/rext_blk_reduce.sv
`timescale 1ns/1ps
module rext_blk_reduce import rext_pkg::*; #(
  parameter int        K     = 2,
  parameter int        BLK_W = 8,
  parameter mod_kind_e KIND  = MOD_PLUS,
  parameter int        RES_W = 3
) (
  input  logic [BLK_W-1:0] blk_i,
  output logic [RES_W-1:0] res_o
);
  localparam int NDIG  = BLK_W / K;
  localparam int SUM_W = K + $clog2(NDIG + 1) + 2;
  localparam int NFOLD = SUM_W;
  localparam int M     = mod_val(K, KIND);

  if (KIND == MOD_MINUS) begin : g_minus
    logic [SUM_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int d = 0; d < NDIG; d++) acc = acc + SUM_W'(blk_i[d*K +: K]);
      // end-around folding: 2^k == 1
      for (int f = 0; f < NFOLD; f++) acc = SUM_W'(acc[K-1:0]) + (acc >> K);
      res_o = (acc == SUM_W'(M)) ? '0 : RES_W'(acc);
    end
  end else begin : g_plus
    localparam logic signed [SUM_W-1:0] M_S = SUM_W'(M);
    logic signed [SUM_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int d = 0; d < NDIG; d++) begin
        if (d % 2 == 0) acc = acc + signed'(SUM_W'(blk_i[d*K +: K]));
        else            acc = acc - signed'(SUM_W'(blk_i[d*K +: K]));
      end
      // alternating fold: 2^k == -1, settles in [-1, 2^k]
      for (int f = 0; f < NFOLD; f++) acc = signed'(SUM_W'(acc[K-1:0])) - (acc >>> K);
      if (acc < 0)    acc = acc + M_S;
      if (acc >= M_S) acc = acc - M_S;
      res_o = RES_W'(acc);
    end
  end
endmodule

// File: rtl/rext_res_add.sv
`timescale 1ns/1ps
module rext_res_add import rext_pkg::*; #(
  parameter int        K     = 2,
  parameter mod_kind_e KIND  = MOD_PLUS,
  parameter int        RES_W = 3,
  parameter bit        SUB   = 1'b0
) (
  input  logic [RES_W-1:0] a_i,
  input  logic [RES_W-1:0] b_i,
  output logic [RES_W-1:0] sum_o
);
  localparam int M = mod_val(K, KIND);

  if (KIND == MOD_MINUS) begin : g_minus
    logic [K:0]   raw;
    logic [K-1:0] wrap;
    assign raw   = {1'b0, a_i} + {1'b0, b_i};
    assign wrap  = raw[K-1:0] + K'(raw[K]);
    assign sum_o = (wrap == {K{1'b1}}) ? '0 : wrap;
  end else begin : g_plus
    localparam int RW = K + 3;
    localparam logic signed [RW-1:0] M_S = RW'(M);
    logic signed [RW-1:0] a_s, b_s, raw, fix;
    assign a_s = signed'(RW'(a_i));
    assign b_s = signed'(RW'(b_i));
    if (SUB) begin : g_sub
      assign raw = a_s - b_s;
      assign fix = (raw < 0) ? raw + M_S : raw;
    end else begin : g_add
      assign raw = a_s + b_s;
      assign fix = (raw >= M_S) ? raw - M_S : raw;
    end
    assign sum_o = RES_W'(fix);
  end
endmodule

// File: rtl/rext_tree.sv
`timescale 1ns/1ps
module rext_tree import rext_pkg::*; #(
  parameter int        NB    = 2,
  parameter int        K     = 2,
  parameter mod_kind_e KIND  = MOD_PLUS,
  parameter int        RES_W = 3,
  parameter bit        SUB0  = 1'b0
) (
  input  logic [NB*RES_W-1:0] leaf_i,
  output logic [RES_W-1:0]    root_o
);
  localparam int LVL = (NB > 1) ? $clog2(NB) : 0;

  logic [RES_W-1:0] node [0:LVL][0:NB-1];

  for (genvar j = 0; j < NB; j++) begin : g_leaf
    assign node[0][j] = leaf_i[j*RES_W +: RES_W];
  end

  for (genvar l = 1; l <= LVL; l++) begin : g_lvl
    localparam int CNT_PREV = ceil_div(NB, 1 << (l - 1));
    for (genvar j = 0; j < NB; j++) begin : g_node
      if (2*j + 1 < CNT_PREV) begin : g_add
        // level 1 pairs an even slice (weight +1) with an odd one
        rext_res_add #(
          .K(K), .KIND(KIND), .RES_W(RES_W), .SUB((l == 1) && SUB0)
        ) u_add (
          .a_i  (node[l-1][2*j]),
          .b_i  (node[l-1][2*j+1]),
          .sum_o(node[l][j])
        );
      end else if (2*j < CNT_PREV) begin : g_pass
        assign node[l][j] = node[l-1][2*j];
      end else begin : g_idle
        assign node[l][j] = '0;
      end
    end
  end

  assign root_o = node[LVL][0];
endmodule

// File: rtl/rext_top.sv
`timescale 1ns/1ps
module rext_top import rext_pkg::*; #(
  parameter int        DATA_W = 16,
  parameter int        K      = 2,
  parameter int        BLK_W  = 8,
  parameter mod_kind_e KIND   = MOD_PLUS,
  localparam int       RES_W  = K + ((KIND == MOD_PLUS) ? 1 : 0)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] op_i,
  output logic [RES_W-1:0]  res_o
);
  localparam int  NB    = ceil_div(DATA_W, BLK_W);
  localparam int  PAD_W = NB * BLK_W;
  localparam bit  SUB0  = (KIND == MOD_PLUS) && (((BLK_W / K) % 2) == 1);

  logic [PAD_W-1:0]    op_pad;
  logic [NB*RES_W-1:0] blk_res;
  logic [RES_W-1:0]    root;

  assign op_pad = PAD_W'(op_i);

  for (genvar b = 0; b < NB; b++) begin : g_blk
    rext_blk_reduce #(
      .K(K), .BLK_W(BLK_W), .KIND(KIND), .RES_W(RES_W)
    ) u_red (
      .blk_i(op_pad[b*BLK_W +: BLK_W]),
      .res_o(blk_res[b*RES_W +: RES_W])
    );
  end

  rext_tree #(
    .NB(NB), .K(K), .KIND(KIND), .RES_W(RES_W), .SUB0(SUB0)
  ) u_tree (
    .leaf_i(blk_res),
    .root_o(root)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_o <= '0;
    else         res_o <= root;
  end
endmodule

// File: rtl/rext_chk.sv
`timescale 1ns/1ps
module rext_chk import rext_pkg::*; #(
  parameter int        DATA_W = 16,
  parameter int        K      = 2,
  parameter int        BLK_W  = 8,
  parameter mod_kind_e KIND   = MOD_PLUS,
  parameter int        RES_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] op_i,
  input logic [RES_W-1:0]  res_o
);
  localparam int M = mod_val(K, KIND);

  always @(negedge clk_i) begin
    if (!rst_ni) assert_reset_clear_R1: assert (res_o == '0);
  end

  assert_res_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(res_o) < M);

  assert_res_matches_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> int'(res_o) == (int'($past(op_i)) % M));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $stable(op_i)) |=> $stable(res_o));

  assert_multiple_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && ((int'($past(op_i)) % M) == 0)) |-> res_o == '0);
endmodule

bind rext_top rext_chk #(
  .DATA_W(DATA_W), .K(K), .BLK_W(BLK_W), .KIND(KIND), .RES_W(RES_W)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .op_i  (op_i),
  .res_o (res_o)
);

// File: tb/rext_top_tb.sv
`timescale 1ns/1ps
module rext_top_tb;
  import rext_pkg::*;

  localparam int NDUT = 6;
  localparam int MODS [NDUT] = '{3, 5, 5, 7, 15, 9};

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] op = '0;
  int          n_chk = 0;
  int          n_err = 0;

  logic [1:0] r3;
  logic [2:0] r5a, r5b, r7;
  logic [3:0] r15, r9;

  always #2.5 clk = ~clk;

  // m=5, s/k even: all slices add
  rext_top #(.DATA_W(16), .K(2), .BLK_W(8), .KIND(MOD_PLUS)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op), .res_o(r5a));
  rext_top #(.DATA_W(16), .K(2), .BLK_W(4), .KIND(MOD_MINUS)) u_dut_m3 (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op), .res_o(r3));
  rext_top #(.DATA_W(16), .K(2), .BLK_W(6), .KIND(MOD_PLUS)) u_dut_m5b (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op), .res_o(r5b));
  rext_top #(.DATA_W(16), .K(3), .BLK_W(6), .KIND(MOD_MINUS)) u_dut_m7 (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op), .res_o(r7));
  rext_top #(.DATA_W(16), .K(4), .BLK_W(16), .KIND(MOD_MINUS)) u_dut_m15 (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op), .res_o(r15));
  rext_top #(.DATA_W(16), .K(3), .BLK_W(3), .KIND(MOD_PLUS)) u_dut_m9 (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op), .res_o(r9));

  function automatic int got(int i);
    case (i)
      0: return int'(r3);
      1: return int'(r5a);
      2: return int'(r5b);
      3: return int'(r7);
      4: return int'(r15);
      default: return int'(r9);
    endcase
  endfunction

  // per-DUT requirement tag for value checks
  function automatic string tag_of(int i);
    case (i)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string req, int m, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s m=%0d op=%h actual=%0d expected=%0d", req, m, op, act, exp);
    end
  endtask

  task automatic check_all(string req);
    for (int i = 0; i < NDUT; i++) begin
      check((req == "") ? tag_of(i) : req, MODS[i], got(i), int'(op) % MODS[i]);
    end
  endtask

  task automatic apply(logic [15:0] v, string req);
    @(negedge clk);
    op = v;
    @(posedge clk);
    #1;
    check_all(req);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    op = 16'hFFFF;
    repeat (3) @(posedge clk);
    #1;
    for (int i = 0; i < NDUT; i++) check("R1", MODS[i], got(i), 0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic t_edges();
    apply(16'h0000, "R9");
    apply(16'hFFFF, "R9");
    apply(16'h8000, "R9");
    apply(16'h0001, "R9");
  endtask

  task automatic t_hold();
    apply(16'h1234, "R2");
    @(posedge clk);
    #1;
    check_all("R2");
    @(negedge clk);
    op = 16'hBEEF;
    #1;
    // still the residue of the old operand before the edge
    for (int i = 0; i < NDUT; i++) check("R2", MODS[i], got(i), 16'h1234 % MODS[i]);
    @(posedge clk);
    #1;
    check_all("R2");
  endtask

  task automatic t_sweep();
    for (int v = 0; v < 65536; v++) begin
      apply(16'(v), "");
      for (int i = 0; i < NDUT; i++) check("R3", MODS[i], int'(got(i) < MODS[i]), 1);
    end
  endtask

  task automatic t_random();
    for (int n = 0; n < 3000; n++) apply(16'($urandom), "");
  endtask

  task automatic t_multiples();
    for (int i = 0; i < NDUT; i++) begin
      for (int j = 0; j <= 65535 / MODS[i] && j < 1000; j++) begin
        apply(16'(j * MODS[i]), "");
        check("R4", MODS[i], got(i), 0);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_edges();
    t_hold();
    t_sweep();
    t_random();
    t_multiples();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule